// File: doc/BRIEF.md
# Single-Request Interrupt Vector Arbiter

This block gathers 64 level-sensitive interrupt lines and presents at most one of them at a time to a processor as a vector request. Lines 0 to 31 come from PCI slots and are gated in groups of four by one mapping register per group. Lines 32 to 63 come from onboard devices, and each has a mapping register of its own. Only the top bit of a mapping register, the enable, can be written. The other bits are fixed identification values that software reads back.

While no request is outstanding, the block looks at every pending line on every cycle. It issues the lowest-numbered pending line whose mapping is enabled, so PCI lines always win over onboard lines. Once issued, a request stays on the output until software withdraws it. Software does this by clearing the line's group (PCI), clearing the line itself (onboard), or removing the enable of the line's mapping. After a withdrawal the block rescans in the same cycle, so a line that is still pending and enabled is issued again.

The register window uses a 16-bit byte address. Bits [15:8] select a region: 0x0C holds the PCI mappings, 0x10 the onboard mappings, 0x14 the PCI group clears and 0x18 the onboard line clears. Each register sits at the word of its 8-byte slot that has address bit 2 set.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After reset, req_valid is 0, req_vec is 0, every enable bit reads 0, and no line is pending.
- R2: The PCI mapping of group g reads at 0x0C04+8g as {enable, 31'h7C0 | g<<2}. The onboard mapping of onboard line k (vector 32+k) reads at 0x1004+8k as {enable, 31'h7E0 + k}.
- R3: A write to a mapping register changes only bit 31, the enable. Bits 30:0 read back unchanged.
- R4: An access whose address has bit 2 clear reads zero, and a write to it has no effect on any register or on the request.
- R5: At most one request is outstanding. While it is outstanding, req_vec does not change, even when a higher-priority line becomes pending, unless software withdraws it.
- R6: With no request outstanding, the block issues the lowest-numbered line that is pending and enabled. PCI line i is enabled by group i/4. Onboard line 32+k is enabled by its own mapping.
- R7: A line driven high before rising edge A becomes pending at A. If it is enabled and nothing is outstanding, req_valid is 1 with its vector after the following edge B, and not before.
- R8: A mapping write with bit 31 = 0 that covers the outstanding line withdraws that request, and the rescan follows in the same cycle.
- R9: A write at 0x1404+32g withdraws the outstanding request if its vector is a PCI line of group g (vector/4 = g). It has no effect for any other group or for onboard vectors.
- R10: A write at 0x1804+8k withdraws the outstanding request only when it is vector 32+k.
- R11: Deasserting a line clears its pending bit but does not withdraw a request already issued for it.
- R12: While no request is outstanding, req_vec is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_lines | input | 64 | Interrupt levels: 0-31 PCI, 32-63 onboard |
| req_valid | output | 1 | A vector request is outstanding |
| req_vec | output | 6 | Number of the outstanding vector |

## Verification
The bench builds the block with its default parameters: eight PCI groups of four lines and 32 onboard lines. This makes every one of the 64 vectors, the full 3-bit group field of the PCI clear address and the full 5-bit slot field of the onboard addresses reachable. Random writes land in all four regions, including slots beyond the eight PCI groups and words with bit 2 clear. The random line toggling therefore drives withdrawal, rescan and aliasing cases across the whole vector range. Directed steps pin down priority between PCI and onboard lines, the two-edge latency, and clears aimed at the wrong group or line.

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
  parameter int PCI_GROUPS  = 8,
  parameter int GROUP_LINES = 4,
  parameter int ONB_LINES   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [PCI_GROUPS*GROUP_LINES+ONB_LINES-1:0] irq_lines,
  output logic        req_valid,
  output logic [$clog2(PCI_GROUPS*GROUP_LINES+ONB_LINES)-1:0] req_vec
);
  localparam int PCI_LINES = PCI_GROUPS * GROUP_LINES;
  localparam int N_LINES   = PCI_LINES + ONB_LINES;
  localparam int VEC_W     = $clog2(N_LINES);
  localparam int GW        = $clog2(PCI_GROUPS);
  localparam int GLW       = $clog2(GROUP_LINES);
  localparam int OW        = $clog2(ONB_LINES);
  localparam logic [7:0] RG_PCI_MAP = 8'h0C;
  localparam logic [7:0] RG_ONB_MAP = 8'h10;
  localparam logic [7:0] RG_PCI_CLR = 8'h14;
  localparam logic [7:0] RG_ONB_CLR = 8'h18;

  logic [PCI_GROUPS-1:0] pci_en, pci_en_nx;
  logic [ONB_LINES-1:0]  onb_en, onb_en_nx;
  logic [N_LINES-1:0]    pend, line_en;
  logic                  found;
  logic [VEC_W-1:0]      pick;

  wire [7:0]    region  = bus_addr[15:8];
  wire [4:0]    slot    = bus_addr[7:3];
  wire [GW-1:0] pslot   = slot[GW-1:0];
  wire [OW-1:0] oslot   = slot[OW-1:0];
  wire [GW-1:0] clr_grp = bus_addr[5 +: GW];
  wire          hit     = bus_wr & bus_addr[2];
  wire          pslot_ok = int'(slot) < PCI_GROUPS;
  wire          oslot_ok = int'(slot) < ONB_LINES;

  wire wr_pci_map = hit && region == RG_PCI_MAP && pslot_ok;
  wire wr_onb_map = hit && region == RG_ONB_MAP && oslot_ok;
  wire wr_pci_clr = hit && region == RG_PCI_CLR;
  wire wr_onb_clr = hit && region == RG_ONB_CLR && oslot_ok;

  wire          req_pci = int'(req_vec) < PCI_LINES;
  wire [GW-1:0] req_grp = req_vec[GLW +: GW];
  wire [OW-1:0] req_onb = OW'(req_vec - VEC_W'(PCI_LINES));

  wire kill = req_valid && (
      (wr_pci_map && !bus_wdata[31] &&  req_pci && req_grp == pslot)   ||
      (wr_onb_map && !bus_wdata[31] && !req_pci && req_onb == oslot)   ||
      (wr_pci_clr &&  req_pci && req_grp == clr_grp)                   ||
      (wr_onb_clr && !req_pci && req_onb == oslot));

  always_comb begin
    pci_en_nx = pci_en;
    onb_en_nx = onb_en;
    if (wr_pci_map) pci_en_nx[pslot] = bus_wdata[31];
    if (wr_onb_map) onb_en_nx[oslot] = bus_wdata[31];
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_en
    if (i < PCI_LINES) begin : g_pci
      assign line_en[i] = pci_en_nx[i / GROUP_LINES];
    end else begin : g_onb
      assign line_en[i] = onb_en_nx[i - PCI_LINES];
    end
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pend[i] && line_en[i]) begin
        found = 1'b1;
        pick  = VEC_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_en    <= '0;
      onb_en    <= '0;
      pend      <= '0;
      req_valid <= 1'b0;
      req_vec   <= '0;
    end else begin
      pci_en <= pci_en_nx;
      onb_en <= onb_en_nx;
      pend   <= irq_lines;
      if (!req_valid || kill) begin
        req_valid <= found;
        req_vec   <= found ? pick : '0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[2]) begin
      if (region == RG_PCI_MAP && pslot_ok)
        bus_rdata = {pci_en[pslot], 31'h7C0 | 31'({pslot, {GLW{1'b0}}})};
      else if (region == RG_ONB_MAP && oslot_ok)
        bus_rdata = {onb_en[oslot], 31'h7E0 + 31'(oslot)};
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !kill) |=> (req_valid && $stable(req_vec)));

  assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bus_wr) |=> req_valid);

  assert_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> |($past(pend) & (N_LINES'(1) << req_vec)));

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> req_vec == '0);
endmodule

// File: tb/sim_irq_vector_arbiter.sv
module sim_irq_vector_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_lines = '0;
  logic        req_valid;
  logic [5:0]  req_vec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vector_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .req_valid(req_valid), .req_vec(req_vec));

  logic [7:0]  m_pci_en;
  logic [31:0] m_onb_en;
  logic [63:0] m_pend;
  logic        m_valid;
  logic [5:0]  m_vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pci_en = '0; m_onb_en = '0; m_pend = '0; m_valid = 0; m_vec = '0;
    end else begin
      logic [7:0]  pe;
      logic [31:0] oe;
      bit kill;
      int sl, grp;
      pe = m_pci_en; oe = m_onb_en; kill = 0;
      sl = int'(bus_addr[7:3]); grp = int'(bus_addr[7:5]);
      if (bus_wr && bus_addr[2]) begin
        case (bus_addr[15:8])
          8'h0C: if (sl < 8) begin
            pe[sl] = bus_wdata[31];
            if (!bus_wdata[31] && m_valid && m_vec < 32 && m_vec / 4 == sl) kill = 1;
          end
          8'h10: begin
            oe[sl] = bus_wdata[31];
            if (!bus_wdata[31] && m_valid && int'(m_vec) == 32 + sl) kill = 1;
          end
          8'h14: if (m_valid && m_vec < 32 && m_vec / 4 == grp) kill = 1;
          8'h18: if (m_valid && int'(m_vec) == 32 + sl) kill = 1;
          default: ;
        endcase
      end
      if (!m_valid || kill) begin
        m_valid = 0; m_vec = '0;
        for (int i = 0; i < 64; i++) begin
          if (m_pend[i] && ((i < 32) ? pe[i / 4] : oe[i - 32])) begin
            m_valid = 1; m_vec = 6'(i);
            break;
          end
        end
      end
      m_pci_en = pe; m_onb_en = oe; m_pend = irq_lines;
    end
  end

  function automatic logic [31:0] exp_rd(logic [15:0] a);
    int sl;
    sl = int'(a[7:3]);
    if (!a[2]) return 32'h0;
    if (a[15:8] == 8'h0C && sl < 8) return {m_pci_en[sl], 31'(32'h7C0 | (sl << 2))};
    if (a[15:8] == 8'h10) return {m_onb_en[sl], 31'(32'h7E0 + sl)};
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_out(string req, logic v, logic [5:0] n);
    chk(req_valid == v && req_vec == n, req, {25'd0, req_valid, req_vec}, {25'd0, v, n});
  endtask

  task automatic chk_model(string req);
    chk_out(req, m_valid, m_vec);
  endtask

  task automatic chk_rd(logic [15:0] a, logic [31:0] exp, string req);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240607));
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1 / R2 reset state and fixed fields
    chk_out("R1", 1'b0, 6'd0);
    chk_rd(16'h0C04, 32'h0000_07C0, "R2");
    chk_rd(16'h0C1C, 32'h0000_07CC, "R2");
    chk_rd(16'h102C, 32'h0000_07E5, "R2");
    // R3 only the enable is writable
    wr(16'h0C1C, 32'hFFFF_FFFF);
    chk_rd(16'h0C1C, 32'h8000_07CC, "R3");
    wr(16'h0C1C, 32'h7FFF_FFFF);
    chk_rd(16'h0C1C, 32'h0000_07CC, "R3");
    wr(16'h0C1C, 32'h8000_0000);
    // R4 word with bit 2 clear
    wr(16'h0C20, 32'h8000_0000);
    chk_rd(16'h0C24, 32'h0000_07D0, "R4");
    chk_rd(16'h0C20, 32'h0, "R4");
    wr(16'h1044, 32'h8000_0000);
    // R7 latency, R6 PCI before onboard
    irq_lines[40] = 1'b1; irq_lines[13] = 1'b1;
    cyc();
    chk_out("R7", 1'b0, 6'd0);
    cyc();
    chk_out("R6", 1'b1, 6'd13);
    irq_lines[12] = 1'b1;
    cyc(); cyc();
    chk_out("R5", 1'b1, 6'd13);
    irq_lines[13] = 1'b0;
    cyc(); cyc();
    chk_out("R11", 1'b1, 6'd13);
    wr(16'h1444, 32'h0);
    chk_out("R9", 1'b1, 6'd13);
    wr(16'h1464, 32'h0);
    chk_out("R9", 1'b1, 6'd12);
    irq_lines[12] = 1'b0;
    cyc();
    wr(16'h1464, 32'h0);
    chk_out("R9", 1'b1, 6'd40);
    wr(16'h184C, 32'h0);
    chk_out("R10", 1'b1, 6'd40);
    wr(16'h1044, 32'h0);
    chk_out("R8", 1'b0, 6'd0);
    chk_out("R12", 1'b0, 6'd0);
    wr(16'h1040, 32'h8000_0000);
    chk_out("R4", 1'b0, 6'd0);
    chk_rd(16'h1044, 32'h0000_07E8, "R4");
    irq_lines[14] = 1'b1;
    cyc(); cyc();
    chk_out("R6", 1'b1, 6'd14);
    wr(16'h0C1C, 32'h0);
    chk_out("R8", 1'b0, 6'd0);
    irq_lines = '0;
    cyc();
    // random phase against the bench model (R5 R6 R8 R9 R10)
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 2 == 0) irq_lines[$urandom % 64] ^= 1'b1;
      if ($urandom % 3 == 0) begin
        logic [7:0] rg;
        case ($urandom % 4)
          0: rg = 8'h0C;
          1: rg = 8'h10;
          2: rg = 8'h14;
          default: rg = 8'h18;
        endcase
        bus_addr  = {rg, 5'($urandom % 32), ($urandom % 4 != 0), 2'b00};
        bus_wdata = $urandom;
        bus_wr    = 1'b1;
      end
      cyc();
      bus_wr = 1'b0;
      chk_model("R5 R6 R8 R9 R10");
      begin
        logic [15:0] ra;
        ra = {(($urandom % 2) != 0) ? 8'h0C : 8'h10, 5'($urandom % 32), 1'($urandom), 2'b00};
        chk_rd(ra, exp_rd(ra), "R2 R3");
      end
    end
    // R1 reset clears enables and request
    rst_n = 1'b0;
    cyc();
    chk_out("R1", 1'b0, 6'd0);
    rst_n = 1'b1;
    for (int g = 0; g < 8; g++)
      chk_rd(16'(16'h0C04 + 8 * g), 32'(32'h7C0 | (g << 2)), "R1");
    chk_rd(16'h1004, 32'h0000_07E0, "R1");
    finish_run();
  end
endmodule